// File: doc/BRIEF.md
# Reloading Down-Count Slice Timer

This block is a periodic timer that software programs through four word-wide registers. A 32-bit counter steps down by one on every clock while the run control is on. After the counter reaches zero it takes the reload value again on the following clock. Each period therefore covers the reload value plus one clocks, and software writes n-1 to get a period of n clocks.

Every wrap can latch an event flag, which software clears by writing a one to it. A level interrupt follows the event flag while the interrupt enable is on. A second flag records that the reload value was changed while the counter was running. Software can read the live count at any moment.

Top module: `slice_timer`

## Requirements
- R1: The count register (word index 2, byte offset 0x8) returns the live counter value, and writes to it leave the counter unchanged.
- R2: While run is on, the counter drops by one per clock. In the clock after it reads zero, it takes the reload value, so one period lasts reload+1 clocks.
- R3: A control write that turns run on when it was off loads the counter with the reload value on that clock edge. While run is off, the counter holds its value.
- R4: The reload register (byte offset 0x0) reads back what was last written to it. A write while running leaves the current countdown alone and is used at the next wrap.
- R5: The control register (byte offset 0x4) holds run in bit 0, interrupt enable in bit 1 and event enable in bit 2. All other bits read zero.
- R6: A wrap sets the event flag (status bit 0) only when event enable is on. With event enable off, the flag keeps its value.
- R7: Writing the status register (byte offset 0xC) clears the event flag where data bit 0 is one and the reload-changed flag where data bit 1 is one. Zero bits in the data leave the matching flag as it is.
- R8: If a wrap that sets the event flag falls on the same clock as a write that clears it, the flag stays set.
- R9: A reload-register write while run is on sets the reload-changed flag (status bit 1). The same write while run is off leaves that flag as it is.
- R10: The interrupt output is high exactly when the event flag and interrupt enable are both on. It stays high until the flag is cleared or the enable is turned off.
- R11: After reset, all four registers read zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (4) | Byte address; bits 3:2 select the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a clear of the event flag that lands on the exact clock of a wrap. The other hard case is a reload write that lands partway through a countdown. In both, the effect depends on the cycle in which the write arrives. The bench polls the live count register at every falling edge until it sees the value just before the target clock, then issues the write so that it is sampled on that clock's edge. A long stretch of writes with short reload values then makes such coincidences frequent, and a cycle-by-cycle model in the bench checks the result.

// File: rtl/slice_timer_pkg.sv
package slice_timer_pkg;

  // Register word index: bus_addr[3:2]
  typedef enum logic [1:0] {
    IDX_RELOAD = 2'd0,
    IDX_CTRL   = 2'd1,
    IDX_COUNT  = 2'd2,
    IDX_STAT   = 2'd3
  } reg_idx_e;

  // Control field positions
  localparam int CTL_RUN = 0;
  localparam int CTL_IEN = 1;
  localparam int CTL_EVE = 2;
  localparam int CTL_W   = 3;

  // Status field positions
  localparam int ST_EVT  = 0;
  localparam int ST_RLD  = 1;
  localparam int ST_W    = 2;

  typedef struct packed {
    logic eve;  // event enable
    logic ien;  // interrupt enable
    logic run;  // counter advances
  } ctrl_t;

  // Write-one-to-clear flag update, set has priority
  function automatic logic w1c_next(input logic cur, input logic set,
                                    input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/slice_timer_regs.sv
module slice_timer_regs
  import slice_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output reg_idx_e          idx,
  output logic [DATA_W-1:0] reload_q,
  output ctrl_t             ctrl_q,
  output logic              reload_wr,
  output logic              run_start,
  output logic              evt_clr,
  output logic              rld_clr,
  output logic              rld_set
);

  localparam int IDX_LSB = 2;

  logic ctrl_wr;
  logic stat_wr;
  logic unused_addr_bits;

  assign idx              = reg_idx_e'(bus_addr[IDX_LSB +: 2]);
  assign unused_addr_bits = ^bus_addr[IDX_LSB-1:0];

  assign reload_wr = bus_wr && (idx == IDX_RELOAD);
  assign ctrl_wr   = bus_wr && (idx == IDX_CTRL);
  assign stat_wr   = bus_wr && (idx == IDX_STAT);

  // Counter restarts only on an off-to-on transition of run
  assign run_start = ctrl_wr && bus_wdata[CTL_RUN] && !ctrl_q.run;
  assign evt_clr   = stat_wr && bus_wdata[ST_EVT];
  assign rld_clr   = stat_wr && bus_wdata[ST_RLD];
  assign rld_set   = reload_wr && ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_wr) begin
      reload_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(bus_wdata[CTL_W-1:0]);
    end
  end

endmodule

// File: rtl/slice_timer_count.sv
module slice_timer_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              run_start,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] cnt_q,
  output logic              wrap_evt
);

  function automatic logic [DATA_W-1:0] step_count(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] rld,
    input logic              go,
    input logic              start
  );
    if (start)          return rld;
    if (!go)            return cur;
    if (cur == '0)      return rld;
    return cur - 1'b1;
  endfunction

  assign wrap_evt = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= step_count(cnt_q, reload, run, run_start);
    end
  end

endmodule

// File: rtl/slice_timer_flags.sv
module slice_timer_flags
  import slice_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic eve,
  input  logic ien,
  input  logic evt_clr,
  input  logic rld_set,
  input  logic rld_clr,
  output logic evt_q,
  output logic rld_q,
  output logic irq
);

  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] clr_v;
  logic [ST_W-1:0] flag_q;

  assign set_v[ST_EVT] = wrap_evt & eve;
  assign set_v[ST_RLD] = rld_set;
  assign clr_v[ST_EVT] = evt_clr;
  assign clr_v[ST_RLD] = rld_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < ST_W; i++) begin
        flag_q[i] <= w1c_next(flag_q[i], set_v[i], clr_v[i]);
      end
    end
  end

  assign evt_q = flag_q[ST_EVT];
  assign rld_q = flag_q[ST_RLD];
  assign irq   = evt_q & ien;

endmodule

// File: rtl/slice_timer.sv
module slice_timer
  import slice_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  reg_idx_e          idx;
  logic [DATA_W-1:0] reload_q;
  ctrl_t             ctrl_q;
  logic              reload_wr;
  logic              run_start;
  logic              evt_clr;
  logic              rld_clr;
  logic              rld_set;
  logic [DATA_W-1:0] cnt_q;
  logic              wrap_evt;
  logic              evt_q;
  logic              rld_q;

  slice_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .idx       (idx),
    .reload_q  (reload_q),
    .ctrl_q    (ctrl_q),
    .reload_wr (reload_wr),
    .run_start (run_start),
    .evt_clr   (evt_clr),
    .rld_clr   (rld_clr),
    .rld_set   (rld_set)
  );

  slice_timer_count #(.DATA_W(DATA_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .run_start (run_start),
    .reload    (reload_q),
    .cnt_q     (cnt_q),
    .wrap_evt  (wrap_evt)
  );

  slice_timer_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_evt (wrap_evt),
    .eve      (ctrl_q.eve),
    .ien      (ctrl_q.ien),
    .evt_clr  (evt_clr),
    .rld_set  (rld_set),
    .rld_clr  (rld_clr),
    .evt_q    (evt_q),
    .rld_q    (rld_q),
    .irq      (irq)
  );

  always_comb begin
    unique case (idx)
      IDX_RELOAD: bus_rdata = reload_q;
      IDX_CTRL:   bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctrl_q};
      IDX_COUNT:  bus_rdata = cnt_q;
      IDX_STAT:   bus_rdata = {{(DATA_W-ST_W){1'b0}}, rld_q, evt_q};
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/slice_timer_chk.sv
module slice_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              ien,
  input logic              eve,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              wrap_evt,
  input logic              run_start,
  input logic              reload_wr,
  input logic              evt_clr,
  input logic              evt_q,
  input logic              rld_q,
  input logic              irq
);

  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_evt) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == $past(reload_q)));

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (cnt_q == $past(reload_q)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !run_start) |=> $stable(cnt_q));

  // R6
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && eve) |=> evt_q);

  // R7
  event_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !(wrap_evt && eve)) |=> !evt_q);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && eve && evt_clr) |=> evt_q);

  // R9
  reload_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && run) |=> rld_q);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  // R10
  irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_q);

endmodule

bind slice_timer slice_timer_chk #(.DATA_W(DATA_W)) u_slice_timer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (ctrl_q.run),
  .ien       (ctrl_q.ien),
  .eve       (ctrl_q.eve),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q),
  .wrap_evt  (wrap_evt),
  .run_start (run_start),
  .reload_wr (reload_wr),
  .evt_clr   (evt_clr),
  .evt_q     (evt_q),
  .rld_q     (rld_q),
  .irq       (irq)
);

// File: tb/test_slice_timer.sv
module test_slice_timer;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [31:0] m_rld, m_cnt;
  bit m_run, m_ien, m_eve, m_evt, m_rf;

  always #(CLK_P/2) clk = ~clk;

  slice_timer i_slice_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Reference model advances on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rld = 0; m_cnt = 0; m_run = 0; m_ien = 0; m_eve = 0;
      m_evt = 0; m_rf = 0;
    end else begin
      int w;
      bit hit_zero, go_now;
      logic [31:0] n_cnt;
      w = bus_addr[3:2];
      hit_zero = m_run && (m_cnt == 0);
      go_now = bus_wr && w == 1 && bus_wdata[0] && !m_run;
      if (go_now) n_cnt = m_rld;
      else if (!m_run) n_cnt = m_cnt;
      else if (hit_zero) n_cnt = m_rld;
      else n_cnt = m_cnt - 1;
      if (hit_zero && m_eve) m_evt = 1;
      else if (bus_wr && w == 3 && bus_wdata[0]) m_evt = 0;
      if (bus_wr && w == 0 && m_run) m_rf = 1;
      else if (bus_wr && w == 3 && bus_wdata[1]) m_rf = 0;
      if (bus_wr && w == 0) m_rld = bus_wdata;
      if (bus_wr && w == 1) begin
        m_run = bus_wdata[0]; m_ien = bus_wdata[1]; m_eve = bus_wdata[2];
      end
      m_cnt = n_cnt;
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      case (bus_addr[3:2])
        2'd0: chk("R4 reload readback", bus_rdata, m_rld);
        2'd1: chk("R5 control readback", bus_rdata, {29'd0, m_eve, m_ien, m_run});
        2'd2: chk("R2 live count", bus_rdata, m_cnt);
        default: chk("R7 status readback", bus_rdata, {30'd0, m_rf, m_evt});
      endcase
      chk("R10 irq level", {31'd0, irq}, {31'd0, m_evt & m_ien});
    end
  end

  // All tasks assume entry just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_count(input logic [31:0] target);
    logic [31:0] v;
    rd(4'h8, v);
    while (v !== target) begin
      step(1);
      rd(4'h8, v);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0;
    int k;
    int unsigned lcg;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R11: reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(a[3:0], v);
      chk("R11 reset register", v, 32'd0);
    end
    chk("R11 reset irq", {31'd0, irq}, 32'd0);

    // R5: only three control bits stored
    wr(4'h4, 32'hFFFF_FFFA);
    rd(4'h4, v);
    chk("R5 control bits", v, 32'd2);
    wr(4'h4, 32'd0);

    // R1: count register ignores writes
    rd(4'h8, c0);
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h8, v);
    chk("R1 count write ignored", v, c0);

    // R3: hold while stopped, load on start
    wr(4'h0, 32'd9);
    rd(4'h8, v);
    chk("R3 hold while stopped", v, c0);
    rd(4'hC, v);
    chk("R9 no flag when stopped", v, 32'd0);
    wr(4'h4, 32'd1);
    rd(4'h8, v);
    chk("R3 start loads reload", v, 32'd9);
    step(1);
    rd(4'h8, v);
    chk("R3 first decrement", v, 32'd8);

    // R4: reload write mid-count applies at next wrap
    wait_count(32'd5);
    wr(4'h0, 32'd2);
    rd(4'h8, v);
    chk("R4 countdown undisturbed", v, 32'd4);
    rd(4'hC, v);
    chk("R9 reload flag set", v, 32'd2);
    wait_count(32'd0);
    step(1);
    rd(4'h8, v);
    chk("R4 new reload used", v, 32'd2);

    // R2: period is reload plus one
    wr(4'h0, 32'd4);
    wait_count(32'd0);
    step(1);
    rd(4'h8, v);
    chk("R2 reload value", v, 32'd4);
    k = 0;
    do begin
      step(1); k++;
      rd(4'h8, v);
    end while (v !== 32'd4);
    chk("R2 period length", k, 32'd5);

    // R6: no event with event enable off
    wr(4'hC, 32'd3);
    step(12);
    rd(4'hC, v);
    chk("R6 event gated off", v, 32'd0);
    chk("R10 irq idle", {31'd0, irq}, 32'd0);

    // R6 / R10: event raises irq, enable masks it
    wr(4'h4, 32'd7);
    step(6);
    rd(4'hC, v);
    chk("R6 event set on wrap", v & 32'd1, 32'd1);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'd5);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(4'h4, 32'd7);
    chk("R10 irq back", {31'd0, irq}, 32'd1);

    // R8: clear on the wrap clock loses to the set
    wait_count(32'd0);
    wr(4'hC, 32'd1);
    rd(4'hC, v);
    chk("R8 set wins over clear", v & 32'd1, 32'd1);

    // R7: per-bit write-one-to-clear
    wr(4'h0, 32'd4);
    wr(4'h4, 32'd4);
    rd(4'hC, v);
    chk("R7 both flags set", v, 32'd3);
    wr(4'hC, 32'd2);
    rd(4'hC, v);
    chk("R7 clear reload flag only", v, 32'd1);
    wr(4'hC, 32'd0);
    rd(4'hC, v);
    chk("R7 zero write no effect", v, 32'd1);
    wr(4'hC, 32'd1);
    rd(4'hC, v);
    chk("R7 clear event flag", v, 32'd0);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // Mixed traffic with short periods, model compared every clock
    lcg = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      int w;
      lcg = lcg * 1103515245 + 12345;
      w = (lcg >> 12) % 4;
      bus_addr = 4'(w << 2);
      if (((lcg >> 20) % 4) == 0) begin
        bus_wr = 1'b1;
        bus_wdata = (w == 0) ? ((lcg >> 8) % 12) : (lcg >> 8);
      end else begin
        bus_wr = 1'b0;
      end
      step(1);
    end
    bus_wr = 1'b0;
    step(2);
    finish_run();
  end

endmodule